// File: doc/BRIEF.md
# Bit-Addressed System Control Latch

This block is a write-only control register on a 16-bit host bus. Each host write sets or clears one control bit. The bit to change is picked by the low three address bits. The new value is the next address bit, so the data bus carries no information and is not wired in.

The latched bits drive six control levels to the rest of the chip:

- a screen-blank level;
- a selector for where the host fetches its vector table;
- a selector for where the sound processor fetches its program;
- a selector for the fixed text layer source;
- a save-RAM write unlock;
- a palette bank select.

The indexes with no defined function are still latched. They appear on a small spare bus, and each write to them raises a one-cycle flag for debug.

One index updates two outputs at once: the vector table selector and the sound program selector. The save-RAM unlock exists only in build variants that enable it. In other variants, writes to that index are dropped.

Top module: `sysctl_latch`

## Requirements
- R1: After reset, every control output, every spare bit and the unmapped flag are 0.
- R2: A write happens only on a clock edge where `wr` and `lane_lo` are both 1. With either of them low, no output changes.
- R3: A write targets index `addr[2:0]` and stores the value `addr[3]` in it.
- R4: Index 0 drives `blank_o`.
- R5: Index 1 loads the same value into both `vec_sel_o` and `snd_src_o`.
- R6: Index 5 drives `fix_src_o`, and index 7 drives `pal_o`.
- R7: Index 6 drives `unlock_o` when the parameter `UNLOCK_EN` is 1. When `UNLOCK_EN` is 0, writes to index 6 are ignored and `unlock_o` stays 0.
- R8: Indexes 2, 3 and 4 are latched into `spare_o[0]`, `spare_o[1]` and `spare_o[2]`. In the cycle after the write edge, `unmapped_o` is 1 for exactly that one cycle.
- R9: `rd_data` is always 0x0000, and reading has no effect on any state.
- R10: A write changes only the output bits tied to its index. All other outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr | input | 1 | Write strobe for the register address |
| lane_lo | input | 1 | Low byte lane enable |
| addr | input | 4 | [2:0] selects the index, [3] is the value written |
| rd_data | output | 16 | Read data, always zero |
| blank_o | output | 1 | Screen blank level |
| vec_sel_o | output | 1 | Host vector table source select |
| snd_src_o | output | 1 | Sound program source select |
| fix_src_o | output | 1 | Fixed layer source select |
| unlock_o | output | 1 | Save-RAM write unlock |
| pal_o | output | 1 | Palette bank select |
| spare_o | output | 3 | Latched values of indexes 2, 3 and 4 |
| unmapped_o | output | 1 | One-cycle pulse after a write to index 2, 3 or 4 |

## Verification
The assertions assume that `wr`, `lane_lo` and `addr` are stable, known values at each rising edge. They also assume that reset is held for at least one edge before the first write. The bench meets both conditions by changing inputs only on the falling edge, and by holding reset low for several cycles before any stimulus. Random traffic mixes valid writes, writes with the byte lane disabled, and idle cycles. A second instance, built with the unlock disabled, receives the same traffic so that both variants of index 6 are covered.

// File: rtl/sysctl_latch.sv
module sysctl_latch #(
  parameter bit UNLOCK_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic        lane_lo,
  input  logic [3:0]  addr,
  output logic [15:0] rd_data,
  output logic        blank_o,
  output logic        vec_sel_o,
  output logic        snd_src_o,
  output logic        fix_src_o,
  output logic        unlock_o,
  output logic        pal_o,
  output logic [2:0]  spare_o,
  output logic        unmapped_o
);
  localparam int NIDX = 8;
  localparam int IW   = $clog2(NIDX);

  logic          wen;
  logic [IW-1:0] idx;
  logic          val;
  logic [NIDX-1:0] bits_q;
  logic          snd_q;
  logic          unm_q;

  assign wen = wr & lane_lo;
  assign idx = addr[IW-1:0];
  assign val = addr[IW];

  for (genvar i = 0; i < NIDX; i++) begin : g_bit
    if (i == 6 && !UNLOCK_EN) begin : g_off
      assign bits_q[i] = 1'b0;
    end else begin : g_on
      always_ff @(posedge clk) begin
        if (!rst_n)                     bits_q[i] <= 1'b0;
        else if (wen && idx == IW'(i))  bits_q[i] <= val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      snd_q <= 1'b0;
    else if (wen && idx == IW'(1))   snd_q <= val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) unm_q <= 1'b0;
    else        unm_q <= wen && (idx == IW'(2) || idx == IW'(3) || idx == IW'(4));
  end

  assign rd_data    = '0;
  assign blank_o    = bits_q[0];
  assign vec_sel_o  = bits_q[1];
  assign snd_src_o  = snd_q;
  assign spare_o    = bits_q[4:2];
  assign fix_src_o  = bits_q[5];
  assign unlock_o   = bits_q[6];
  assign pal_o      = bits_q[7];
  assign unmapped_o = unm_q;
endmodule

// File: rtl/sysctl_latch_chk.sv
module sysctl_latch_chk #(
  parameter bit UNLOCK_EN = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr,
  input logic       lane_lo,
  input logic [3:0] addr,
  input logic       blank_o,
  input logic       vec_sel_o,
  input logic       snd_src_o,
  input logic       fix_src_o,
  input logic       unlock_o,
  input logic       pal_o,
  input logic [2:0] spare_o,
  input logic       unmapped_o
);
  logic wen;
  logic [9:0] outs;
  assign wen  = wr & lane_lo;
  assign outs = {blank_o, vec_sel_o, snd_src_o, fix_src_o, unlock_o, pal_o, spare_o, unmapped_o};

  AST_NO_LANE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !lane_lo && !unmapped_o) |=> $stable(outs)) else $error("no-lane write changed outputs"); // R2

  AST_BLANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && addr[2:0] == 3'd0) |=> (blank_o == $past(addr[3]))) else $error("blank load"); // R4

  AST_DUAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && addr[2:0] == 3'd1) |=> (vec_sel_o == $past(addr[3]) && snd_src_o == $past(addr[3]))) else $error("dual load"); // R5

  AST_PAIR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    vec_sel_o == snd_src_o) else $error("vector and sound selects diverged"); // R5

  AST_UNLOCK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !UNLOCK_EN |-> !unlock_o) else $error("unlock set while disabled"); // R7

  AST_UNMAPPED_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unmapped_o) |-> $past(wen && addr[2:0] inside {3'd2, 3'd3, 3'd4})) else $error("spurious unmapped flag"); // R8

  AST_UNMAPPED_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (unmapped_o && !(wen && addr[2:0] inside {3'd2, 3'd3, 3'd4})) |=> !unmapped_o) else $error("unmapped flag stuck"); // R8
endmodule

bind sysctl_latch sysctl_latch_chk #(.UNLOCK_EN(UNLOCK_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr(wr), .lane_lo(lane_lo), .addr(addr),
  .blank_o(blank_o), .vec_sel_o(vec_sel_o), .snd_src_o(snd_src_o),
  .fix_src_o(fix_src_o), .unlock_o(unlock_o), .pal_o(pal_o),
  .spare_o(spare_o), .unmapped_o(unmapped_o)
);

// File: tb/sysctl_latch_tb.sv
`timescale 1ns/1ps
module sysctl_latch_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0;
  logic lane_lo = 1'b0;
  logic [3:0] addr = 4'd0;
  always #2 clk = ~clk;

  logic [15:0] rd_a, rd_b;
  logic blk_a, vec_a, snd_a, fix_a, unl_a, pal_a, unm_a;
  logic blk_b, vec_b, snd_b, fix_b, unl_b, pal_b, unm_b;
  logic [2:0] spr_a, spr_b;

  sysctl_latch #(.UNLOCK_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr(wr), .lane_lo(lane_lo), .addr(addr),
    .rd_data(rd_a), .blank_o(blk_a), .vec_sel_o(vec_a), .snd_src_o(snd_a),
    .fix_src_o(fix_a), .unlock_o(unl_a), .pal_o(pal_a), .spare_o(spr_a),
    .unmapped_o(unm_a));

  sysctl_latch #(.UNLOCK_EN(1'b0)) u_dut_nounl (
    .clk(clk), .rst_n(rst_n), .wr(wr), .lane_lo(lane_lo), .addr(addr),
    .rd_data(rd_b), .blank_o(blk_b), .vec_sel_o(vec_b), .snd_src_o(snd_b),
    .fix_src_o(fix_b), .unlock_o(unl_b), .pal_o(pal_b), .spare_o(spr_b),
    .unmapped_o(unm_b));

  int total = 0;
  int bad = 0;
  logic [7:0] m;
  logic m_unm;

  function automatic logic [15:0] pack_exp(input logic [7:0] b, input logic u, input bit en);
    return {b[7], en ? b[6] : 1'b0, b[5], b[4:2], b[1], b[1], b[0], u, 6'd0};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic compare(input string req);
    chk(req, {pal_a, unl_a, fix_a, spr_a, snd_a, vec_a, blk_a, unm_a, 6'd0}, pack_exp(m, m_unm, 1'b1));
    chk(req, {pal_b, unl_b, fix_b, spr_b, snd_b, vec_b, blk_b, unm_b, 6'd0}, pack_exp(m, m_unm, 1'b0));
    chk("R9", rd_a | rd_b, 16'h0000);
  endtask

  task automatic cyc(input logic w, input logic l, input logic [3:0] a, input string req);
    @(negedge clk);
    wr = w; lane_lo = l; addr = a;
    @(posedge clk);
    m_unm = w && l && (a[2:0] inside {3'd2, 3'd3, 3'd4});
    if (w && l) m[a[2:0]] = a[3];
    #1;
    compare(req);
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m = '0; m_unm = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    compare("R1");
    // R4 blank set and clear
    cyc(1, 1, 4'b1000, "R4");
    cyc(1, 1, 4'b0000, "R4");
    // R5 dual load
    cyc(1, 1, 4'b1001, "R5");
    cyc(1, 1, 4'b0001, "R5");
    cyc(1, 1, 4'b1001, "R5");
    // R6
    cyc(1, 1, 4'b1101, "R6");
    cyc(1, 1, 4'b1111, "R6");
    // R7 unlock, both variants
    cyc(1, 1, 4'b1110, "R7");
    cyc(0, 0, 4'b0000, "R7");
    // R8 spare and pulse, back-to-back
    cyc(1, 1, 4'b1010, "R8");
    cyc(1, 1, 4'b1011, "R8");
    cyc(1, 1, 4'b1100, "R8");
    cyc(0, 0, 4'b0000, "R8");
    // R2 lane disabled / no strobe
    cyc(1, 0, 4'b0000, "R2");
    cyc(0, 1, 4'b0111, "R2");
    // R10 single bit change leaves others
    cyc(1, 1, 4'b0101, "R10");
    // R3 random traffic
    for (int i = 0; i < 2000; i++) begin
      logic [3:0] a;
      int k;
      a = 4'($urandom);
      k = $urandom_range(0, 9);
      cyc(k < 6, k != 7, a, "R3");
    end
    // R1 reset again
    @(negedge clk); rst_n = 1'b0; wr = 1'b0;
    @(posedge clk); #1;
    m = '0; m_unm = 1'b0;
    compare("R1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule